// File: doc/BRIEF.md
# Standby Mode Power Controller

This block governs the low-power idle behaviour of a processor. Software programs a single byte-wide control register through a simple write strobe and read-data bus. When the core executes its sleep instruction, it pulses `sleep_req`. One control bit then decides what happens. With the bit set, the block stops the core, bus and I/O clocks through their enables, pulls the active-low `standby_n` output low, and parks the bus: control lines are forced inactive and every address bit is forced to 1. With the bit clear, the sleep strobe behaves as a plain halt. The clocks keep running and the active-low `halt_n` output goes low.

Standby ends on reset, on the non-maskable interrupt, or on any maskable interrupt line whose enable is set. Bus request can also end standby, but only when it has been allowed. Once a wake event is accepted, `standby_n` returns high at once so that an external oscillator can restart. The clocks stay stopped and the bus stays parked for a warm-up interval, chosen by a 3-bit field: either no delay or a power-of-two count of reference-clock cycles. The warm-up counter runs on the free-running `clk`, which is never gated. The parameter `WARM_SHIFT` divides every warm-up count by 2^WARM_SHIFT so that short simulations can check exact lengths.

Top module: `stby_pwr_ctl`

## Requirements
- R1: The control register reads 0x00 after reset. Bit 7 is the standby enable, bit 6 is the bus-request wake permission, and bits 2..0 are the warm-up select. All of them are written by `reg_we` with `reg_wdata` and read back on `reg_rdata`.
- R2: Bits 5..3 of the control register always read as 0, whatever value is written to them.
- R3: With bit 7 set, a sleep strobe sampled while running drives `standby_n` low and `core_clk_en`, `bus_clk_en` and `io_clk_en` low from the next cycle on.
- R4: While in standby or warm-up, `ctl_idle` is 1 and `addr_force` is all ones. In the running and halted states both are 0.
- R5: In standby, an asserted `nmi_req`, or any `int_req[i]` with `int_en[i]` set, ends standby. An `int_req[i]` whose `int_en[i]` is clear does not end standby.
- R6: In standby, `bus_req` ends standby only when control bit 6 is 1. Otherwise it is ignored.
- R7: With bit 7 clear, a sleep strobe drives `halt_n` low from the next cycle on, while all clock enables stay 1 and `standby_n` stays 1. `nmi_req` or an enabled `int_req` returns `halt_n` to 1 on the next cycle. `bus_req` does not end the halt.
- R8: Let the wake be sampled at edge e. With warm-up code 000, the clock enables are 1 after edge e. With codes 001, 010 and 011, they become 1 after edge e+N, where N is 2^(16-WARM_SHIFT), 2^(17-WARM_SHIFT) or 2^(19-WARM_SHIFT) respectively. Codes 100 to 111 behave as 011.
- R9: `standby_n` returns to 1 in the cycle right after the wake is accepted, while the clocks stay disabled for the whole warm-up.
- R10: A wake event that arrives during warm-up neither restarts nor shortens the warm-up count.
- R11: Synchronous `rst` ends standby or warm-up at the next edge, with no warm-up delay. All clock enables become 1 and the register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, never gated |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| sleep_req | input | 1 | Sleep instruction strobe from the core |
| nmi_req | input | 1 | Non-maskable interrupt request (active high) |
| int_req | input | N_IRQ | Maskable interrupt requests (active high) |
| int_en | input | N_IRQ | Per-line wake enables for int_req |
| bus_req | input | 1 | External bus request (active high) |
| standby_n | output | 1 | Active-low standby indication |
| halt_n | output | 1 | Active-low halt indication |
| core_clk_en | output | 1 | Internal clock enable |
| bus_clk_en | output | 1 | Bus clock output enable |
| io_clk_en | output | 1 | I/O clock output enable |
| ctl_idle | output | 1 | Forces bus control outputs inactive |
| addr_force | output | ADDR_W | Per-bit force-to-1 mask for the address bus |

## Verification
Two events can fall in the same cycle: a wake arriving while the warm-up counter is already running, and the counter's own terminal count. The bench provokes this by pulsing the non-maskable interrupt in the middle of a warm-up. It then checks that the clocks resume on exactly the cycle predicted from the select code alone. The bench also samples randomized wake-source patterns in standby, including masked interrupts and bus request with and without permission. Each outcome is compared against a bench function of the pattern and the control bits, and the same check is repeated for a reset that lands inside warm-up.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_HALT = 2'd1,
        PM_STBY = 2'd2,
        PM_WARM = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic       deep_en;    // bit 7
        logic       breq_wake;  // bit 6
        logic [2:0] rsvd;       // bits 5..3
        logic [2:0] warm_sel;   // bits 2..0
    } ctl_reg_t;

    localparam logic [7:0] CTL_WMASK = 8'hC7;

    // Number of reference-clock cycles of warm-up for a select code
    function automatic logic [31:0] warm_cycles(input logic [2:0] sel, input int unsigned shift);
        case (sel)
            3'd0:    warm_cycles = 32'd0;
            3'd1:    warm_cycles = 32'd1 << (16 - shift);
            3'd2:    warm_cycles = 32'd1 << (17 - shift);
            default: warm_cycles = 32'd1 << (19 - shift);
        endcase
    endfunction

endpackage

// File: rtl/stby_ctl_reg.sv
module stby_ctl_reg
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       deep_en,
    output logic       breq_wake,
    output logic [2:0] warm_sel
);
    ctl_reg_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (we)
            ctl_q <= ctl_reg_t'(wdata & CTL_WMASK);
    end

    assign rdata     = ctl_q;
    assign deep_en   = ctl_q.deep_en;
    assign breq_wake = ctl_q.breq_wake;
    assign warm_sel  = ctl_q.warm_sel;

    // R1: without a write strobe the register keeps its value
    assert_ctl_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !we |=> (rdata == $past(rdata)));

endmodule

// File: rtl/stby_wake_src.sv
module stby_wake_src #(
    parameter int N_IRQ = 4
) (
    input  logic             nmi_req,
    input  logic [N_IRQ-1:0] int_req,
    input  logic [N_IRQ-1:0] int_en,
    input  logic             bus_req,
    input  logic             breq_wake,
    output logic             wake_stby,
    output logic             wake_halt
);
    logic [N_IRQ-1:0] irq_hit;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        assign irq_hit[i] = int_req[i] & int_en[i];
    end

    assign wake_halt = nmi_req | (|irq_hit);
    assign wake_stby = wake_halt | (bus_req & breq_wake);

endmodule

// File: rtl/stby_warm_ctr.sv
module stby_warm_ctr #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
#(
    parameter int WARM_SHIFT = 0,
    parameter int CNT_W      = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             deep_en,
    input  logic [2:0]       warm_sel,
    input  logic             wake_stby,
    input  logic             wake_halt,
    input  logic             expired,
    output logic             warm_load,
    output logic [CNT_W-1:0] warm_val,
    output pm_state_e        state
);
    pm_state_e   nxt;
    logic [31:0] wlen;

    assign wlen      = warm_cycles(warm_sel, WARM_SHIFT);
    assign warm_val  = CNT_W'(wlen - 32'd1);
    assign warm_load = (state == PM_STBY) && wake_stby && (warm_sel != 3'd0);

    always_comb begin
        nxt = state;
        unique case (state)
            PM_RUN:  if (sleep_req) nxt = deep_en ? PM_STBY : PM_HALT;
            PM_HALT: if (wake_halt) nxt = PM_RUN;
            PM_STBY: if (wake_stby) nxt = (warm_sel == 3'd0) ? PM_RUN : PM_WARM;
            PM_WARM: if (expired)   nxt = PM_RUN;
            default: nxt = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PM_RUN;
        else     state <= nxt;
    end

    // R3: enabled sleep from run enters standby
    assert_stby_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (state == PM_RUN && sleep_req && deep_en) |=> (state == PM_STBY));
    // R5: standby persists without a wake source
    assert_stby_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == PM_STBY && !wake_stby) |=> (state == PM_STBY));
    // R10: warm-up persists until the counter expires, whatever wakes arrive
    assert_warm_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (state == PM_WARM && !expired) |=> (state == PM_WARM));
    // R11: reset always returns to run
    assert_rst_run_R11: assert property (@(posedge clk)
        rst |=> (state == PM_RUN));

endmodule

// File: rtl/stby_pwr_ctl.sv
module stby_pwr_ctl
    import stby_pkg::*;
#(
    parameter int N_IRQ      = 4,
    parameter int ADDR_W     = 32,
    parameter int WARM_SHIFT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              sleep_req,
    input  logic              nmi_req,
    input  logic [N_IRQ-1:0]  int_req,
    input  logic [N_IRQ-1:0]  int_en,
    input  logic              bus_req,
    output logic              standby_n,
    output logic              halt_n,
    output logic              core_clk_en,
    output logic              bus_clk_en,
    output logic              io_clk_en,
    output logic              ctl_idle,
    output logic [ADDR_W-1:0] addr_force
);
    localparam int CNT_W = 19 - WARM_SHIFT;

    logic             deep_en, breq_wake, wake_stby, wake_halt;
    logic             warm_load, expired, parked;
    logic [2:0]       warm_sel;
    logic [CNT_W-1:0] warm_val;
    pm_state_e        state;

    stby_ctl_reg u_reg (
        .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata), .rdata(reg_rdata),
        .deep_en(deep_en), .breq_wake(breq_wake), .warm_sel(warm_sel)
    );

    stby_wake_src #(.N_IRQ(N_IRQ)) u_wake (
        .nmi_req(nmi_req), .int_req(int_req), .int_en(int_en), .bus_req(bus_req),
        .breq_wake(breq_wake), .wake_stby(wake_stby), .wake_halt(wake_halt)
    );

    stby_warm_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst(rst), .load(warm_load), .load_val(warm_val), .expired(expired)
    );

    stby_fsm #(.WARM_SHIFT(WARM_SHIFT), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .deep_en(deep_en),
        .warm_sel(warm_sel), .wake_stby(wake_stby), .wake_halt(wake_halt),
        .expired(expired), .warm_load(warm_load), .warm_val(warm_val), .state(state)
    );

    assign parked      = (state == PM_STBY) || (state == PM_WARM);
    assign standby_n   = (state != PM_STBY);
    assign halt_n      = (state != PM_HALT);
    assign core_clk_en = !parked;
    assign bus_clk_en  = !parked;
    assign io_clk_en   = !parked;
    assign ctl_idle    = parked;
    assign addr_force  = {ADDR_W{parked}};

    // R4: a low standby output always comes with a parked bus and stopped clocks
    assert_park_R4: assert property (@(posedge clk) disable iff (rst)
        !standby_n |-> (ctl_idle && (&addr_force) && !bus_clk_en));
    // R7: halt and standby never coincide, and halt keeps the clocks running
    assert_halt_clk_R7: assert property (@(posedge clk) disable iff (rst)
        !halt_n |-> (standby_n && core_clk_en));
    // R9: leaving standby for warm-up keeps the clocks stopped
    assert_warm_clk_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(standby_n) && ctl_idle) |-> !core_clk_en);

endmodule

// File: tb/stby_pwr_ctl_tb.sv
module stby_pwr_ctl_tb_top;
    localparam int N_IRQ  = 4;
    localparam int ADDR_W = 32;
    localparam int SHIFT  = 12;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_we = 0, sleep_req = 0, nmi_req = 0, bus_req = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic [N_IRQ-1:0] int_req = 0, int_en = 0;
    logic standby_n, halt_n, core_clk_en, bus_clk_en, io_clk_en, ctl_idle;
    logic [ADDR_W-1:0] addr_force;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    stby_pwr_ctl #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .WARM_SHIFT(SHIFT)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sleep_req(sleep_req), .nmi_req(nmi_req), .int_req(int_req), .int_en(int_en),
        .bus_req(bus_req), .standby_n(standby_n), .halt_n(halt_n), .core_clk_en(core_clk_en),
        .bus_clk_en(bus_clk_en), .io_clk_en(io_clk_en), .ctl_idle(ctl_idle), .addr_force(addr_force)
    );

    function automatic int exp_cycles(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 1 + (1 << (16 - SHIFT));
            3'd2:    return 1 + (1 << (17 - SHIFT));
            default: return 1 + (1 << (19 - SHIFT));
        endcase
    endfunction

    function automatic logic exp_wake(input logic nmi, input logic [3:0] rq, input logic [3:0] en,
                                      input logic br, input logic brx);
        return nmi | (|(rq & en)) | (br & brx);
    endfunction

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we = 1; reg_wdata = v; step(); reg_we = 0;
    endtask

    task automatic go_sleep();
        sleep_req = 1; step(); sleep_req = 0;
    endtask

    task automatic parked_chk(input string tag);
        chk(tag, {standby_n, core_clk_en, bus_clk_en, io_clk_en, ctl_idle}, 5'b00001);
        chk(tag, addr_force, {ADDR_W{1'b1}});
    endtask

    // Wake with nmi, optionally pulse nmi again mid warm-up, return cycles until clocks resume
    task automatic wake_measure(input logic [2:0] code, input logic repulse, output int n);
        nmi_req = 1; step(); nmi_req = 0; n = 1;
        chk("R9 standby_n high after wake", standby_n, 1'b1);
        if (code != 0) chk("R9 clocks still off", core_clk_en, 1'b0);
        while (!core_clk_en && n < 1000) begin
            if (repulse && n == 5) nmi_req = 1; else nmi_req = 0;
            step(); n++;
        end
        nmi_req = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        void'($urandom(32'd4242));
        step(); step(); rst = 0; step();

        // Reset state
        chk("R1 reset value", reg_rdata, 8'h00);
        chk("R4 run outputs", {standby_n, halt_n, core_clk_en, bus_clk_en, io_clk_en, ctl_idle}, 6'b111110);
        chk("R4 addr not forced", addr_force, '0);

        // Register write/read, reserved bits masked
        for (int i = 0; i < 20; i++) begin
            logic [7:0] v = 8'($urandom);
            wr(v);
            chk("R1 R2 readback", reg_rdata, v & 8'hC7);
        end
        wr(8'h38);
        chk("R2 reserved only write", reg_rdata, 8'h00);

        // Warm-up length per code
        for (int c = 0; c < 8; c++) begin
            wr(8'h80 | 8'(c));
            go_sleep();
            parked_chk("R3 R4 standby entered");
            step();
            sleep_req = 1; step(); sleep_req = 0;
            parked_chk("R3 sleep ignored in standby");
            wake_measure(3'(c), 1'b0, n);
            chk("R8 warm-up cycles", n, exp_cycles(3'(c)));
            chk("R4 unparked after warm-up", {ctl_idle, halt_n}, 2'b01);
        end

        // Wake during warm-up absorbed
        wr(8'h82);
        go_sleep();
        wake_measure(3'd2, 1'b1, n);
        chk("R10 wake in warm-up absorbed", n, exp_cycles(3'd2));

        // Random wake-source patterns
        for (int i = 0; i < 40; i++) begin
            logic brx = 1'($urandom);
            logic nm  = (($urandom % 6) == 0);
            logic [3:0] rq = 4'($urandom), en = 4'($urandom);
            logic br = 1'($urandom);
            logic w;
            wr(brx ? 8'hC0 : 8'h80);
            go_sleep();
            w = exp_wake(nm, rq, en, br, brx);
            nmi_req = nm; int_req = rq; int_en = en; bus_req = br;
            step();
            nmi_req = 0; int_req = 0; int_en = 0; bus_req = 0;
            if (br && !nm && !(|(rq & en)))
                chk("R6 bus request wake gating", standby_n, brx);
            else
                chk("R5 wake source decode", standby_n, w);
            if (!standby_n) begin nmi_req = 1; step(); nmi_req = 0; end
        end

        // Halt mode
        wr(8'h41);
        go_sleep();
        chk("R7 halt entered", {halt_n, standby_n, core_clk_en, bus_clk_en, io_clk_en, ctl_idle}, 6'b011110);
        bus_req = 1; step(); bus_req = 0;
        chk("R7 bus request ignored in halt", halt_n, 1'b0);
        int_req = 4'b0100; int_en = 4'b0000; step();
        chk("R7 masked int ignored in halt", halt_n, 1'b0);
        int_en = 4'b0100; step(); int_req = 0; int_en = 0;
        chk("R7 halt released", halt_n, 1'b1);

        // Reset inside warm-up
        wr(8'h83);
        go_sleep();
        nmi_req = 1; step(); nmi_req = 0;
        repeat (3) step();
        chk("R11 in warm-up before reset", core_clk_en, 1'b0);
        rst = 1; step(); rst = 0;
        chk("R11 clocks on after reset", {core_clk_en, bus_clk_en, io_clk_en, standby_n, ctl_idle}, 5'b11110);
        chk("R11 register cleared", reg_rdata, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule